// File: doc/BRIEF.md
# Prescaled Event IRQ Timer

This block is an interrupt timer for a cartridge-side controller. It has two stages: an 8-bit prescaler and an 8-bit main counter behind it. Each qualifying event steps the prescaler. When the masked prescaler value crosses its boundary, the main counter steps once. When the main counter rolls over, the block requests an interrupt. The interrupt line is a level output. It stays high until software acknowledges it.

Software sets up the timer by writing to eight offsets on the CPU write bus. The block decodes a write as a fixed base address plus the three low address bits. The values loaded into the prescaler and the main counter are first XORed with a key that software has programmed.

A mode register controls counting:
- The count direction: up, down, or stopped.
- The prescaler width: 3 bits or 8 bits.
- Which of four event strobes drives the count: CPU cycle, video address-line toggle, video read, or CPU write.

A video-read strobe counts as two prescaler events.

Top module: `prescaled_irq_timer`

## Requirements
- R1: After reset, `irqOut` is low, the IRQ is disabled, counting is stopped and the XOR key is 0x00, so a write to offset 4 or 5 loads its data unchanged.
- R2: A write to offset 0 sets the IRQ enable to data bit 0. When bit 0 is 0, it also clears a pending IRQ. When bit 0 is 1, a pending IRQ is left as it is.
- R3: A write to offset 2 disables the IRQ and clears a pending IRQ. A write to offset 3 enables the IRQ and leaves the prescaler and main counter untouched.
- R4: A write to offset 6 stores the key. A write to offset 4 loads the prescaler with data XOR key, and a write to offset 5 loads the main counter with data XOR key. Changing the key later does not alter values that are already loaded.
- R5: A write to offset 1 sets the mode. Mode bits 7:6 select the direction: 01 counts up, 10 counts down, and 00 or 11 freeze both counters.
- R6: When mode bit 2 is 1, the prescaler boundary is tested on its low 3 bits (mask 0x07). When mode bit 2 is 0, it is tested on all 8 bits (mask 0xFF).
- R7: Counting up, each event adds one to the prescaler. The main counter adds one when (prescaler & mask) becomes 0. A main counter that becomes 0x00 while the IRQ is enabled raises `irqOut`.
- R8: Counting down, each event subtracts one from the prescaler. The main counter subtracts one when (prescaler & mask) becomes equal to the mask. A main counter that becomes 0xFF while the IRQ is enabled raises `irqOut`.
- R9: Mode bits 1:0 choose the event source: 0 selects `evtCpuCycle`, 1 selects `evtAddrToggle`, 2 selects `evtVidRead` and 3 selects `evtCpuWrite`. Strobes on the sources that are not selected are ignored. One `evtVidRead` strobe counts as two prescaler events.
- R10: Writes to offset 7 and to offsets outside the ones listed above have no effect on the IRQ, the enable, the mode or the counters.
- R11: `irqOut` stays high through further wraps until it is cleared as R2 or R3 describe. A wrap while the IRQ is disabled does not raise `irqOut`.
- R12: A write takes effect at the clock edge that samples `wrEn`. `irqOut` goes high at the clock edge that samples the event causing the wrap.
- R13: A write is accepted only when `wrAddr` bits 15:3 match the base address 0xC000 bits 15:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| evtCpuCycle | input | 1 | CPU cycle event strobe |
| evtAddrToggle | input | 1 | Video address line toggle event strobe |
| evtVidRead | input | 1 | Video read (address change) event strobe |
| evtCpuWrite | input | 1 | CPU write event strobe |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- Each strobe is a clean one-cycle pulse, synchronous to `clk`.
- A counter load and a wrap of that same counter never arrive in the same cycle.
- An acknowledge write is never paired with an event that would re-raise the IRQ in that cycle.

The stimulus keeps within these assumptions. It changes inputs only on the falling edge, and it issues writes and event pulses in separate cycles, so every write is complete before the next event arrives. Each wrap therefore comes from a counter state that a single write fixed beforehand.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  parameter int DATA_W = 8;
  parameter int MAX_STEPS = 2;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  // Strobes from the control section to the counting datapath.
  typedef struct packed {
    logic              loadPre;
    logic              loadCnt;
    logic [DATA_W-1:0] loadVal;
    logic              countUp;
    logic              countDown;
    logic              shortPre;
    logic [STEP_W-1:0] steps;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtCpuCycle,
  input  logic              evtAddrToggle,
  input  logic              evtVidRead,
  input  logic              evtCpuWrite,
  input  logic              wrap,
  output ctrlStrobes_t      strobes,
  output logic              irqEn,
  output logic              irqOut
);
  localparam int OFS_W = 3;

  logic [1:0]        dirField;
  logic              shortPre;
  logic [1:0]        srcSel;
  logic [DATA_W-1:0] key;
  logic              wrHit;
  logic [OFS_W-1:0]  ofs;
  logic              ackWrite;
  logic              evtSel;

  assign wrHit = wrEn && (wrAddr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign ofs   = wrAddr[OFS_W-1:0];
  assign ackWrite = wrHit && ((ofs == 3'd2) || (ofs == 3'd0 && !wrData[0]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirField <= 2'b00;
      shortPre <= 1'b0;
      srcSel   <= 2'b00;
      key      <= '0;
      irqEn    <= 1'b0;
    end else if (wrHit) begin
      case (ofs)
        3'd0: irqEn <= wrData[0];
        3'd1: begin
          dirField <= wrData[7:6];
          shortPre <= wrData[2];
          srcSel   <= wrData[1:0];
        end
        3'd2: irqEn <= 1'b0;
        3'd3: irqEn <= 1'b1;
        3'd6: key   <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            irqOut <= 1'b0;
    else if (ackWrite)    irqOut <= 1'b0;
    else if (wrap && irqEn) irqOut <= 1'b1;
  end

  always_comb begin
    case (srcSel)
      2'd0:    evtSel = evtCpuCycle;
      2'd1:    evtSel = evtAddrToggle;
      2'd2:    evtSel = evtVidRead;
      default: evtSel = evtCpuWrite;
    endcase
  end

  always_comb begin
    strobes.loadPre   = wrHit && (ofs == 3'd4);
    strobes.loadCnt   = wrHit && (ofs == 3'd5);
    strobes.loadVal   = wrData ^ key;
    strobes.countUp   = (dirField == 2'b01);
    strobes.countDown = (dirField == 2'b10);
    strobes.shortPre  = shortPre;
    if (!evtSel || !(strobes.countUp || strobes.countDown))
      strobes.steps = '0;
    else if (srcSel == 2'd2)
      strobes.steps = STEP_W'(MAX_STEPS);
    else
      strobes.steps = STEP_W'(1);
  end
endmodule

// File: rtl/irq_timer_datapath.sv
module irq_timer_datapath
  import irq_timer_pkg::*;
#(
  parameter int SHORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] preVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              wrap
);
  localparam logic [DATA_W-1:0] SHORT_MASK = DATA_W'((1 << SHORT_W) - 1);
  localparam logic [DATA_W-1:0] FULL_MASK  = '1;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] preNext;
  logic [DATA_W-1:0] cntNext;

  assign mask = strobes.shortPre ? SHORT_MASK : FULL_MASK;

  always_comb begin
    preNext = preVal;
    cntNext = cntVal;
    wrap    = 1'b0;
    for (int i = 0; i < MAX_STEPS; i++) begin
      if (STEP_W'(i) < strobes.steps) begin
        if (strobes.countUp) begin
          preNext = preNext + 1'b1;
          if ((preNext & mask) == '0) begin
            cntNext = cntNext + 1'b1;
            if (cntNext == '0) wrap = 1'b1;
          end
        end else if (strobes.countDown) begin
          preNext = preNext - 1'b1;
          if ((preNext & mask) == mask) begin
            cntNext = cntNext - 1'b1;
            if (cntNext == FULL_MASK) wrap = 1'b1;
          end
        end
      end
    end
    if (strobes.loadPre) preNext = strobes.loadVal;
    if (strobes.loadCnt) cntNext = strobes.loadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preVal <= '0;
      cntVal <= '0;
    end else begin
      preVal <= preNext;
      cntVal <= cntNext;
    end
  end
endmodule

// File: rtl/prescaled_irq_timer.sv
module prescaled_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000,
  parameter int SHORT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtCpuCycle,
  input  logic              evtAddrToggle,
  input  logic              evtVidRead,
  input  logic              evtCpuWrite,
  output logic              irqOut
);
  ctrlStrobes_t      strobes;
  logic              wrap;
  logic              irqEn;
  logic [DATA_W-1:0] preVal;
  logic [DATA_W-1:0] cntVal;

  irq_timer_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtCpuCycle(evtCpuCycle), .evtAddrToggle(evtAddrToggle),
    .evtVidRead(evtVidRead), .evtCpuWrite(evtCpuWrite),
    .wrap(wrap), .strobes(strobes), .irqEn(irqEn), .irqOut(irqOut)
  );

  irq_timer_datapath #(.SHORT_W(SHORT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .preVal(preVal), .cntVal(cntVal), .wrap(wrap)
  );
endmodule

// File: rtl/irq_timer_checker.sv
module irq_timer_checker
  import irq_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic              irqEn,
  input logic              countUp,
  input logic              countDown,
  input logic [DATA_W-1:0] preVal,
  input logic [DATA_W-1:0] cntVal
);
  logic       hit;
  logic [2:0] ofs;
  logic       clearW;

  assign hit = wrEn && (wrAddr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign ofs = wrAddr[2:0];
  assign clearW = hit && ((ofs == 3'd2) || (ofs == 3'd0 && !wrData[0]));

  a_r2_zero_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    hit && ofs == 3'd0 && !wrData[0] |=> !irqOut && !irqEn);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    hit && ofs == 3'd2 |=> !irqOut && !irqEn);

  a_r3_enable_keeps_counts: assert property (@(posedge clk) disable iff (!rstN)
    hit && ofs == 3'd3 && !countUp && !countDown |=> irqEn && $stable(preVal) && $stable(cntVal));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !clearW |=> irqOut);

  a_r11_no_raise_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut && !irqEn |=> !irqOut);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !countUp && !countDown && !(hit && (ofs == 3'd4 || ofs == 3'd5)) |=> $stable(preVal) && $stable(cntVal));

  a_r10_offset7_inert: assert property (@(posedge clk) disable iff (!rstN)
    hit && ofs == 3'd7 |=> $stable(irqEn) && $stable(countUp) && $stable(countDown));
endmodule

bind prescaled_irq_timer irq_timer_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irqOut(irqOut), .irqEn(irqEn), .countUp(strobes.countUp),
  .countDown(strobes.countDown), .preVal(preVal), .cntVal(cntVal)
);

// File: tb/test_prescaled_irq_timer.sv
`timescale 1ns/1ps
module test_prescaled_irq_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        evtCpuCycle = 1'b0;
  logic        evtAddrToggle = 1'b0;
  logic        evtVidRead = 1'b0;
  logic        evtCpuWrite = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prescaled_irq_timer i_prescaled_irq_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtCpuCycle(evtCpuCycle), .evtAddrToggle(evtAddrToggle),
    .evtVidRead(evtVidRead), .evtCpuWrite(evtCpuWrite), .irqOut(irqOut)
  );

  // {key, prescaler data, counter data, mode, events until IRQ}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'hFE, 8'hFF, 8'h44, 16'd2},    // R7 R6: up, 3-bit, cpu cycle
    {8'h5A, 8'h5F, 8'hA4, 8'h40, 16'd507},  // R4 R7: keyed loads pre=05 cnt=FE
    {8'h00, 8'h02, 8'h00, 8'h84, 16'd3},    // R8 R6: down, 3-bit
    {8'hFF, 8'hFE, 8'hFE, 8'h83, 16'd258},  // R8 R9: down, 8-bit, cpu write
    {8'h00, 8'hF9, 8'hFF, 8'h46, 16'd4},    // R9: video read counts double
    {8'h0F, 8'hF0, 8'hF0, 8'h41, 16'd1}     // R9 R4: addr toggle, pre=cnt=FF
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irqOut=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ev(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (src)
        0: evtCpuCycle = 1'b1;
        1: evtAddrToggle = 1'b1;
        2: evtVidRead = 1'b1;
        default: evtCpuWrite = 1'b1;
      endcase
      @(negedge clk);
      evtCpuCycle = 1'b0; evtAddrToggle = 1'b0; evtVidRead = 1'b0; evtCpuWrite = 1'b0;
    end
  endtask

  // Arm: stop, acknowledge, load FF/FF with key 0, set mode, enable.
  task automatic armFull(input logic [7:0] mode);
    wr(16'hC002, 8'h00);
    wr(16'hC001, 8'h00);
    wr(16'hC006, 8'h00);
    wr(16'hC004, 8'hFF);
    wr(16'hC005, 8'hFF);
    wr(16'hC001, mode);
    wr(16'hC003, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset irq low", irqOut, 1'b0);

    // R1: key resets to zero, counting stopped before mode write
    ev(0, 5);
    wr(16'hC004, 8'hFF);
    wr(16'hC005, 8'hFF);
    wr(16'hC001, 8'h44);
    wr(16'hC003, 8'h00);
    chk("R1 no irq before event", irqOut, 1'b0);
    ev(0, 1);
    chk("R1 unkeyed load wraps on first event", irqOut, 1'b1);

    for (int r = 0; r < 6; r++) begin
      logic [7:0] k, p, c, m;
      int n;
      {k, p, c, m} = VEC[r][47:16];
      n = int'(VEC[r][15:0]);
      wr(16'hC002, 8'h00);
      wr(16'hC001, 8'h00);
      wr(16'hC006, k);
      wr(16'hC004, p);
      wr(16'hC005, c);
      wr(16'hC001, m);
      wr(16'hC003, 8'h00);
      ev(int'(m[1:0]), n - 1);
      chk($sformatf("R7 R8 R12 row %0d quiet before last event", r), irqOut, 1'b0);
      ev(int'(m[1:0]), 1);
      chk($sformatf("R7 R8 R12 row %0d irq at last event", r), irqOut, 1'b1);
    end

    // R5: both stop codes freeze counters
    armFull(8'h04);
    ev(0, 20);
    chk("R5 stop code 00 no irq", irqOut, 1'b0);
    wr(16'hC001, 8'hC4);
    ev(0, 20);
    chk("R5 stop code 11 no irq", irqOut, 1'b0);
    wr(16'hC001, 8'h44);
    ev(0, 1);
    chk("R5 counters held while stopped", irqOut, 1'b1);

    // R11 sticky; R13 off-base write ignored; R2 bit0 handling
    ev(0, 10);
    chk("R11 irq stays high over later wraps", irqOut, 1'b1);
    wr(16'hD002, 8'h00);
    chk("R13 off-base ack ignored", irqOut, 1'b1);
    wr(16'hC007, 8'hFF);
    chk("R10 offset 7 leaves irq", irqOut, 1'b1);
    wr(16'hC000, 8'h01);
    chk("R2 enable write keeps pending", irqOut, 1'b1);
    wr(16'hC000, 8'h02);
    chk("R2 bit0 clear acknowledges", irqOut, 1'b0);

    // R3 ack via offset 2
    armFull(8'h44);
    ev(0, 1);
    chk("R3 setup irq raised", irqOut, 1'b1);
    wr(16'hC002, 8'hFF);
    chk("R3 offset 2 acknowledges", irqOut, 1'b0);

    // R11 wrap while disabled; R3 enable keeps counters (pre=cnt=00 after wrap)
    armFull(8'h44);
    wr(16'hC002, 8'h00);
    ev(0, 1);
    chk("R11 disabled wrap no irq", irqOut, 1'b0);
    wr(16'hC003, 8'h00);
    ev(0, 2047);
    chk("R3 enable kept counters, not yet", irqOut, 1'b0);
    ev(0, 1);
    chk("R3 enable kept counters, wrap", irqOut, 1'b1);

    // R9: unselected sources ignored
    armFull(8'h44);
    ev(1, 5);
    ev(2, 5);
    ev(3, 5);
    chk("R9 unselected strobes ignored", irqOut, 1'b0);
    ev(0, 1);
    chk("R9 selected strobe counts", irqOut, 1'b1);

    // R4 key change after load; R10 offset 7 and 0xC00? unused offsets inert
    wr(16'hC002, 8'h00);
    wr(16'hC001, 8'h00);
    wr(16'hC006, 8'h33);
    wr(16'hC004, 8'hCD);
    wr(16'hC005, 8'hCC);
    wr(16'hC006, 8'h99);
    wr(16'hC007, 8'hFF);
    wr(16'hC001, 8'h44);
    wr(16'hC003, 8'h00);
    ev(0, 1);
    chk("R4 R10 one event short", irqOut, 1'b0);
    ev(0, 1);
    chk("R4 R10 keyed load unaffected by later key", irqOut, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule